// File: doc/BRIEF.md
# Shadowed-Commit PWM Channel

This block drives one pulse-width-modulated output from three programmed values: a clock divider (SCALE), a period length in counter steps (SPAN) and a high time in counter steps (HIGH). A prescaler turns the source clock into one counter step every SCALE + 1 clocks. A period counter then walks through SPAN steps. The output is high for the first HIGH steps of every period.

Software writes the three values into a pending copy. Writing SCALE or SPAN only changes that pending copy. Writing HIGH arms a commit. At the end of the running period, all three pending values move into the active copy together, so no period ever mixes old and new settings. Reads return the active values plus a status bit that shows whether a commit is still waiting. The write port is a plain register strobe with no back-pressure: a write is accepted in the cycle it is presented.

An enable input starts and stops the channel. When enable is low, the output is held low and the counters are cleared. When enable goes high, any pending values are loaded at once and a fresh period begins.

Top module: `pwm_shadow_chan`

## Requirements
- R1: The period lasts (SCALE + 1) × SPAN clock cycles. A SPAN of 0 behaves as 1.
- R2: Each period starts with (SCALE + 1) × HIGH cycles of high output, and the output is low for the rest of the period. HIGH = 0 keeps the output low throughout. HIGH ≥ SPAN keeps it high throughout.
- R3: A write to select 0 (SCALE) or select 1 (SPAN) changes only the pending copy. The output, the readback and the status bit do not change until a later HIGH write is committed.
- R4: A write to select 2 (HIGH) sets the commit-pending status from the next cycle. The status reads back as bit 0 at select 3.
- R5: A pending commit moves SCALE, SPAN and HIGH into the active copy together, on the clock edge that ends the running period, and never earlier. The status then clears.
- R6: Several HIGH writes before one boundary result in a single commit that uses the most recently written values.
- R7: While enable is low, the output is low in the same cycle and the counters are held at zero. On the first clock edge with enable high, pending values are loaded and the pending status clears. A new period starts in the next cycle.
- R8: A read of select 0, 1 or 2 returns the active SCALE, SPAN or HIGH value combinationally.
- R9: After reset, the active and pending values are SCALE 0, SPAN 255 and HIGH 0, no commit is pending, and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 SCALE, 1 SPAN, 2 HIGH |
| wr_data | input | FW | Write data |
| rd_sel | input | 2 | Read select: 0 SCALE, 1 SPAN, 2 HIGH, 3 status |
| rd_data | output | FW | Active value, or the pending flag in bit 0 |
| pwm_out | output | 1 | PWM output |

## Verification
The bench targets these corner cases:

- **HIGH written near the end of a period.** A design that commits immediately would produce one truncated period with a wrong high count.
- **SCALE and SPAN written without HIGH.** A leaky shadow would show the new period at once.
- **Two HIGH writes before one boundary.** A design that locks in the first value would apply the stale duty.
- **HIGH of 0, HIGH above SPAN, and SPAN of 0.** Off-by-one comparisons show up here as stray one-cycle pulses.
- **Enable toggled mid-period.** An output that lags by a cycle would stay high after enable falls. Values written while disabled that fail to load would leave the status bit stuck high.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  // register selects shared by the write and read ports
  typedef enum logic [1:0] {
    SEL_SCALE = 2'd0,
    SEL_SPAN  = 2'd1,
    SEL_HIGH  = 2'd2,
    SEL_STAT  = 2'd3
  } sel_e;

  localparam int unsigned NUM_FIELDS = 3;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int          FW       = 8,
  parameter int unsigned RST_SPAN = 255
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [1:0]                     wr_sel,
  input  logic [FW-1:0]                  wr_data,
  input  logic                           load_now,
  output logic [NUM_FIELDS-1:0][FW-1:0]  act,
  output logic                           pending
);
  localparam int NF = NUM_FIELDS;

  function automatic logic [FW-1:0] rst_val(input int idx);
    return (idx == int'(SEL_SPAN)) ? FW'(RST_SPAN) : '0;
  endfunction

  logic pending_q;
  logic hit_high;

  assign hit_high = wr_en && (wr_sel == SEL_HIGH);

  // one pending/active pair per field
  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic [FW-1:0] pend_q;
    logic [FW-1:0] act_q;
    logic          hit;

    assign hit = wr_en && (wr_sel == 2'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= rst_val(g);
        act_q  <= rst_val(g);
      end else begin
        if (hit) pend_q <= wr_data;
        if (load_now && pending_q) act_q <= pend_q;
      end
    end

    assign act[g] = act_q;
  end

  // a HIGH write arms the commit; a load that is not overlapped by a
  // fresh HIGH write disarms it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending_q <= 1'b0;
    else if (hit_high) pending_q <= 1'b1;
    else if (load_now) pending_q <= 1'b0;
  end

  assign pending = pending_q;
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [FW-1:0] limit,
  output logic          tick
);
  logic [FW-1:0] div_q;

  assign tick = run && (div_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + FW'(1);
  end
endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [FW-1:0] span,
  input  logic [FW-1:0] high,
  output logic          last,
  output logic          wave
);
  logic [FW-1:0] step_q;
  logic [FW-1:0] span_eff;

  assign span_eff = (span == '0) ? FW'(1) : span;
  assign last     = run && tick && (step_q == span_eff - FW'(1));
  assign wave     = run && (step_q < high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    step_q <= '0;
    else if (!run) step_q <= '0;
    else if (tick) step_q <= last ? '0 : step_q + FW'(1);
  end
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
#(
  parameter int          FW       = 8,
  parameter int unsigned RST_SPAN = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [FW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [FW-1:0] rd_data,
  output logic          pwm_out
);
  logic [NUM_FIELDS-1:0][FW-1:0] act;
  logic [FW-1:0] act_scale, act_span, act_high;
  logic run_q, counting, start, period_end, load_now, pend_st, tick, wave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= en;
  end

  assign counting = en && run_q;
  assign start    = en && !run_q;
  assign load_now = start || period_end;

  assign act_scale = act[SEL_SCALE];
  assign act_span  = act[SEL_SPAN];
  assign act_high  = act[SEL_HIGH];

  pwm_shadow_regs #(.FW(FW), .RST_SPAN(RST_SPAN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .load_now(load_now), .act(act), .pending(pend_st)
  );

  pwm_prescale #(.FW(FW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(counting), .limit(act_scale), .tick(tick)
  );

  pwm_period #(.FW(FW)) u_per (
    .clk(clk), .rst_n(rst_n), .run(counting), .tick(tick),
    .span(act_span), .high(act_high), .last(period_end), .wave(wave)
  );

  assign pwm_out = wave;

  always_comb begin
    case (sel_e'(rd_sel))
      SEL_SCALE: rd_data = act_scale;
      SEL_SPAN:  rd_data = act_span;
      SEL_HIGH:  rd_data = act_high;
      default:   rd_data = FW'(pend_st);
    endcase
  end
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          pwm_out,
  input logic          pending,
  input logic          run_q,
  input logic          boundary,
  input logic [FW-1:0] scale,
  input logic [FW-1:0] span,
  input logic [FW-1:0] high
);
  assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  assert_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> pending);

  assert_no_early_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && !boundary) |=> $stable({scale, span, high}));

  assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && pending && !(wr_en && wr_sel == 2'd2)) |=> !pending);

  assert_shadow_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != 2'd2 && !pending) |=> !pending);

  assert_zero_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (high == '0) |-> !pwm_out);

  assert_full_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && high >= ((span == '0) ? FW'(1) : span)) |-> pwm_out);
endmodule

bind pwm_shadow_chan pwm_shadow_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
  .pwm_out(pwm_out), .pending(pend_st), .run_q(run_q), .boundary(period_end),
  .scale(act_scale), .span(act_span), .high(act_high)
);

// File: tb/sim_pwm_shadow_chan.sv
module sim_pwm_shadow_chan;
  localparam int FW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst_n, en, wr_en, pwm_out;
  logic [1:0]    wr_sel, rd_sel;
  logic [FW-1:0] wr_data, rd_data;

  pwm_shadow_chan #(.FW(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  int    errs = 0;
  int    checks = 0;
  string tag = "R9";
  bit    done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int span_eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // behavioural reference: index 0 scale, 1 span, 2 high
  int m_act[3];
  int m_pnd[3];
  bit m_pend, m_run;
  int pc, cc;

  always @(posedge clk) begin
    bit ld;
    bit wh;
    if (!rst_n) begin
      m_act = '{0, 255, 0};
      m_pnd = '{0, 255, 0};
      m_pend = 0; m_run = 0; pc = 0; cc = 0;
    end else begin
      ld = 0;
      wh = wr_en && int'(wr_sel) == 2;
      if (!en) begin
        m_run = 0; pc = 0; cc = 0;
      end else if (!m_run) begin
        m_run = 1; pc = 0; cc = 0; ld = 1;
      end else if (pc == m_act[0]) begin
        pc = 0;
        if (cc == span_eff(m_act[1]) - 1) begin cc = 0; ld = 1; end
        else cc++;
      end else pc++;
      if (ld && m_pend) for (int k = 0; k < 3; k++) m_act[k] = m_pnd[k];
      if (wr_en && int'(wr_sel) < 3) m_pnd[int'(wr_sel)] = int'(wr_data);
      if (wh) m_pend = 1;
      else if (ld) m_pend = 0;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    bit mp;
    int mr;
    if (rst_n && !done) begin
      mp = en && m_run && (cc < m_act[2]);
      mr = (int'(rd_sel) == 3) ? int'(m_pend) : m_act[int'(rd_sel)];
      chk(pwm_out == mp, tag, "pwm_out vs model", int'(pwm_out), int'(mp));
      chk(int'(rd_data) == mr, "R8", "rd_data vs model", int'(rd_data), mr);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input int d);
    step();
    wr_en = 1'b1; wr_sel = 2'(a); wr_data = FW'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string req);
    step();
    rd_sel = 2'(a);
    @(negedge clk);
    chk(int'(rd_data) == exp, req, $sformatf("read sel %0d", a), int'(rd_data), exp);
  endtask

  // restart with a fresh setting, then count over whole periods
  task automatic measure(input int p, input int m, input int d, input int n, input string req);
    int len, hi, rises, me;
    bit prev;
    tag = req;
    step(); en = 1'b0;
    wr(0, p); wr(1, m); wr(2, d);
    step(); en = 1'b1;
    @(posedge clk);
    me = span_eff(m);
    len = n * (p + 1) * me;
    hi = 0; rises = 0; prev = 0;
    repeat (len) begin
      @(negedge clk);
      if (pwm_out) hi++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
    chk(hi == n * (p + 1) * ((d < me) ? d : me), req, "high cycles", hi,
        n * (p + 1) * ((d < me) ? d : me));
    if (d > 0 && d < me) chk(rises == n, "R1", "periods in window", rises, n);
  endtask

  // any window one period long holds the same number of high cycles
  task automatic window(input int len, input int exp, input string req);
    int hi = 0;
    repeat (len) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk(hi == exp, req, "high cycles in window", hi, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL %s watchdog expired: actual=1 expected=0", tag);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 0; en = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R9", "output after reset", int'(pwm_out), 0);
    rd(0, 0, "R9"); rd(1, 255, "R9"); rd(2, 0, "R9"); rd(3, 0, "R9");

    measure(1, 10, 4, 3, "R1");
    measure(0, 5, 0, 4, "R2");
    measure(2, 4, 9, 2, "R2");
    measure(3, 0, 1, 5, "R1");

    // R3: shadow-only writes
    measure(1, 10, 4, 1, "R2");
    tag = "R3";
    wr(0, 5); wr(1, 20);
    rd(0, 1, "R3"); rd(1, 10, "R3"); rd(3, 0, "R3");
    window(20, 8, "R3");

    // R4/R5: commit deferred to the boundary, all fields together
    measure(1, 10, 4, 1, "R2");
    tag = "R5";
    wr(0, 5); wr(1, 20); wr(2, 6);
    rd(3, 1, "R4"); rd(2, 4, "R5"); rd(0, 1, "R5");
    repeat (20) step();
    rd(0, 5, "R5"); rd(1, 20, "R5"); rd(2, 6, "R5"); rd(3, 0, "R4");
    window(120, 36, "R5");

    // R6: latest HIGH wins, one commit
    measure(0, 10, 2, 1, "R2");
    tag = "R6";
    wr(2, 3); wr(2, 8);
    rd(2, 2, "R6");
    repeat (12) step();
    rd(2, 8, "R6"); rd(3, 0, "R6");
    window(10, 8, "R6");

    // R7: enable off/on
    tag = "R7";
    step(); en = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R7", "output right after disable", int'(pwm_out), 0);
    wr(2, 1);
    rd(3, 1, "R7"); rd(2, 8, "R7");
    repeat (5) begin
      @(negedge clk);
      chk(pwm_out == 1'b0, "R7", "output while disabled", int'(pwm_out), 0);
    end
    step(); en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(pwm_out == 1'b1, "R7", "first cycle of new period", int'(pwm_out), 1);
    rd(2, 1, "R7"); rd(3, 0, "R7");
    repeat (5) step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule